// File: doc/BRIEF.md
# Hardware Semaphore Lock Bank

This block is a register-mapped bank of hardware mutual-exclusion flags that several bus masters share. Each flag occupies one 32-bit word. A master claims a flag by reading its word. The read is an atomic test-and-set: it returns the flag's previous state and leaves the flag set. A result of 0 means the caller now holds the flag. A result of 1 means another master holds it, and the caller should back off and retry later. The holder gives the flag up by writing zero to the same word.

A read-only status word tells software how large the bank is. It holds the flag count divided by 32 as a one-hot field. The bank size is a build-time parameter limited to 32, 64, 128 or 256. The bus is a plain single-cycle register port. Read data comes back on the cycle after the read strobe. A vector of the current flag states is also brought out so the rest of the chip can observe them.

Top module: `hw_semaphore_bank`

## Requirements
- R1: A read of lock word i while flag i is clear returns 0 on bus_rdata and sets flag i.
- R2: A read of lock word i while flag i is set returns 1 on bus_rdata, and flag i stays set.
- R3: A write of the value 0 to lock word i clears flag i.
- R4: A write of any non-zero value to a lock word leaves every flag unchanged.
- R5: Lock word i is at byte offset 0x800 + 4*i, for i from 0 to NUM_LOCKS-1. Only word-aligned offsets (bits 1:0 equal to 0) select a lock word.
- R6: A read of byte offset 0x014 returns (NUM_LOCKS/32) << 24. For the legal sizes this sets exactly one of bits 24 to 27, and all other bits read 0.
- R7: A read and a zero write that target the same lock word in the same cycle act as if the write happened first. The read returns 0 and the flag ends up set.
- R8: After reset every flag is clear, lock_taken is all zeros and bus_rdata is 0.
- R9: A read of any offset that is neither a lock word nor the status word returns 0 and changes no flag. A write to such an offset changes no flag. bus_rdata is 0 in any cycle after a cycle with no read.
- R10: bus_rdata carries the result of a read in the cycle after the read strobe. lock_taken shows the effect of a read or write on the same clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_rd | input | 1 | Read strobe (test-and-set on lock words) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| lock_taken | output | NUM_LOCKS | Current state of every flag |

## Verification
Every result of this block is due one clock edge after its strobe. The bench drives each access on a falling edge, which puts it on the bus for exactly one rising edge. It then reads both bus_rdata and lock_taken at the next falling edge and compares them with a flag model kept in the bench. A strobe is never left up across a second rising edge, so each check belongs to exactly one access. This applies to the same-cycle read-and-release case, to idle cycles and to accesses at unmapped offsets.

// File: rtl/hw_semaphore_bank.sv
module hw_semaphore_bank #(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_LOCKS-1:0] lock_taken
);

  localparam int unsigned IDX_W = $clog2(NUM_LOCKS);
  localparam logic [ADDR_W-1:0] LOCK_BASE = ADDR_W'(12'h800);
  localparam logic [ADDR_W-1:0] LOCK_END  = ADDR_W'(12'h800 + 4 * NUM_LOCKS);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(12'h014);
  localparam logic [31:0] STAT_WORD = 32'(NUM_LOCKS / 32) << 24;

  logic [NUM_LOCKS-1:0] flags_q, rel_vec, acq_vec, after_rel;
  logic [ADDR_W-1:0]    offs;
  logic [IDX_W-1:0]     idx;
  logic                 lock_hit, stat_hit, rd_bit;
  logic [31:0]          rdata_q, rdata_d;

  assign offs     = bus_addr - LOCK_BASE;
  assign idx      = offs[IDX_W+1:2];
  assign lock_hit = (bus_addr[1:0] == 2'b00) && (bus_addr >= LOCK_BASE) && (bus_addr < LOCK_END);
  assign stat_hit = (bus_addr == STAT_ADDR);

  assign rel_vec   = (bus_wr && lock_hit && bus_wdata == 32'd0) ? (NUM_LOCKS'(1) << idx) : '0;
  assign acq_vec   = (bus_rd && lock_hit) ? (NUM_LOCKS'(1) << idx) : '0;
  assign after_rel = flags_q & ~rel_vec;
  assign rd_bit    = after_rel[idx];

  always_comb begin
    rdata_d = 32'd0;
    if (bus_rd) begin
      if (lock_hit)      rdata_d = {31'd0, rd_bit};
      else if (stat_hit) rdata_d = STAT_WORD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      rdata_q <= 32'd0;
    end else begin
      flags_q <= after_rel | acq_vec;
      rdata_q <= rdata_d;
    end
  end

  assign lock_taken = flags_q;
  assign bus_rdata  = rdata_q;

  a_r1_free_read_claims: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && lock_hit && !lock_taken[idx]) |=> (bus_rdata == 32'd0 && lock_taken[$past(idx)]));

  a_r2_busy_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && lock_hit && lock_taken[idx] && !(bus_wr && bus_wdata == 32'd0))
      |=> (bus_rdata == 32'd1 && lock_taken[$past(idx)]));

  a_r3_zero_write_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && lock_hit && bus_wdata == 32'd0) |=> !lock_taken[$past(idx)]);

  a_r4_nonzero_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && bus_wdata != 32'd0) |=> $stable(lock_taken));

  a_r7_release_then_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_wr && lock_hit && bus_wdata == 32'd0) |=> (bus_rdata == 32'd0 && lock_taken[$past(idx)]));

  a_r9_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && !lock_hit && !stat_hit) |=> (bus_rdata == 32'd0 && $stable(lock_taken)));

  a_r9_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == 32'd0);

  a_r6_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && stat_hit) |=> ($onehot0(bus_rdata[27:24]) && bus_rdata[27:24] != 4'd0 && bus_rdata[23:0] == 24'd0));

endmodule

// File: tb/hw_semaphore_bank_tb.sv
module hw_semaphore_bank_tb_top;
  localparam int unsigned N = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] lock_taken;
  logic [N-1:0] model = '0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hw_semaphore_bank #(.NUM_LOCKS(N), .ADDR_W(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_taken(lock_taken));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [11:0] a, input logic rd, input logic wr, input logic [31:0] wd);
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  function automatic logic [11:0] lk(input int i);
    return 12'(12'h800 + 4 * i);
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R8 flags after reset", 32'(lock_taken), 32'd0);
    chk("R8 rdata after reset", bus_rdata, 32'd0);

    access(12'h014, 1, 0, 0);
    chk("R6 status word", bus_rdata, (32'(N) / 32) << 24);

    for (int i = 0; i < N; i++) begin
      access(lk(i), 1, 0, 0);
      model[i] = 1'b1;
      chk("R1 free read returns 0", bus_rdata, 32'd0);
      chk("R10 R5 flag set same edge", 32'(lock_taken), 32'(model));
      access(lk(i), 1, 0, 0);
      chk("R2 busy read returns 1", bus_rdata, 32'd1);
      chk("R2 flags unchanged", 32'(lock_taken), 32'(model));
    end

    @(negedge clk);
    chk("R9 idle rdata zero", bus_rdata, 32'd0);

    for (int i = 0; i < N; i++) begin
      access(lk(i), 0, 1, 32'h1 << (i % 32));
      chk("R4 nonzero write inert", 32'(lock_taken), 32'(model));
    end

    for (int i = 0; i < N; i += 2) begin
      access(lk(i), 0, 1, 0);
      model[i] = 1'b0;
      chk("R3 zero write frees", 32'(lock_taken), 32'(model));
    end

    access(lk(4) | 12'h001, 1, 0, 0);
    chk("R5 R9 unaligned read data", bus_rdata, 32'd0);
    chk("R5 R9 unaligned read flags", 32'(lock_taken), 32'(model));
    access(lk(N), 1, 0, 0);
    chk("R5 R9 past last lock data", bus_rdata, 32'd0);
    chk("R5 R9 past last lock flags", 32'(lock_taken), 32'(model));
    access(12'h000, 1, 0, 0);
    chk("R9 offset 0 read", bus_rdata, 32'd0);
    access(lk(N), 0, 1, 0);
    chk("R9 unmapped write flags", 32'(lock_taken), 32'(model));

    access(lk(3), 1, 1, 0);
    model[3] = 1'b1;
    chk("R7 read+release data", bus_rdata, 32'd0);
    chk("R7 read+release flags", 32'(lock_taken), 32'(model));
    access(lk(5), 1, 1, 32'h5);
    chk("R7 R4 read+nonzero data", bus_rdata, 32'd1);
    chk("R7 R4 read+nonzero flags", 32'(lock_taken), 32'(model));
    access(lk(6), 1, 1, 0);
    model[6] = 1'b1;
    chk("R7 free read+release data", bus_rdata, 32'd0);
    chk("R7 free read+release flags", 32'(lock_taken), 32'(model));

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model = '0;
    chk("R8 flags after second reset", 32'(lock_taken), 32'd0);
    access(lk(N - 1), 1, 0, 0);
    chk("R8 R1 read after reset", bus_rdata, 32'd0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule